// File: doc/BRIEF.md
# Interruption Prioritizer and Vectoring Unit

This block sits beside the instruction pipeline and performs the hardware half of entering an interruption handler. Each cycle it looks at a 32-bit vector of pending interruption requests, where bit n stands for vector number n. If any recognised vector is pending, it picks exactly one according to a fixed priority list that spans four timing groups, and in the following cycle it presents the handler fetch address, the forced status word, privilege zero, the saved copy of the old status word and the captured fault details.

The unit also keeps a two-entry copy of the instruction address queue (space and offset, front and back). That copy follows the live queue while the queue-enable bit of the status word is set, and stays frozen once it is clear. A return-from-interruption strobe swaps the saved status word and privilege back onto the next-status outputs. The core then reloads its address queue from the frozen copy. The core is expected to apply `pswNext` and `privNext` whenever `entryValid` or `resumeValid` pulses.

Status word bit positions used throughout: bit 0 = Q (queue enable), bit 1 = I (external interrupt unmask), bit 2 = E (endian), bit 3 = M (machine-check mask). The remaining bits are other defined bits.

Top module: `intr_entry_unit`

## Requirements
- R1: When several recognised vectors are pending in the same cycle, the one taken is the first pending entry of the order 1; 2, 3, 4, 5, 29; 6, 7, 15, 16, 17, 26, 27, 28, 18, 19, 20, 21, 31, 22; 23, 24, 25 (group 1, then 2, 3, 4). The vector number taken is shown on `entryVector`, and `entryValid` pulses for one cycle in the cycle after the request is sampled.
- R2: Request bits 0, 8 to 14 and 30 are not recognised. A cycle whose only pending bits are among them produces no `entryValid` and leaves `pswNext` unchanged.
- R3: `handlerAddr` equals `vecBase` with its low 11 bits cleared, plus 32 times the vector taken.
- R4: On entry, `pswNext` has bit 2 (E) equal to `defaultEndian`, bit 3 (M) set only for vector 1, and every other bit 0.
- R5: On entry, `privNext` is 0.
- R6: On entry, `savedPsw` takes `pswAfter` for vectors 23, 24 and 25 and `pswBefore` for every other vector. `privIn` is saved alongside it.
- R7: On entry, `iirOut`, `isrOut` and `iorOut` load `faultInsn`, `faultSpace` and `faultOff` only if bit 0 (Q) of the status word being saved is 1. Otherwise they keep their previous values.
- R8: In a cycle without entry or return, the four interruption queue outputs load the instruction queue inputs if bit 0 of `pswBefore` is 1 and hold otherwise. In an entry cycle the Q bit of the saved status word decides instead, and in a return cycle the queue outputs hold.
- R9: A `rfiReq` with no recognised request pulses `resumeValid` one cycle later. It loads `pswNext` with the saved status word and `privNext` with the saved privilege, and the interruption queue outputs stay unchanged for the core to reload from.
- R10: If a recognised request and `rfiReq` arrive in the same cycle, the entry is taken and the return is ignored (`resumeValid` stays 0).
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPending | input | 32 | Pending request bits, bit n = vector n |
| rfiReq | input | 1 | Return-from-interruption strobe |
| pswBefore | input | 8 | Status word at the start of the current instruction |
| pswAfter | input | 8 | Status word after the current instruction completes |
| privIn | input | 2 | Current privilege level |
| defaultEndian | input | 1 | Value forced into the E bit on entry |
| vecBase | input | 32 | Vector table base (low 11 bits ignored) |
| iaSpaceFront | input | 16 | Live instruction queue, front space |
| iaSpaceBack | input | 16 | Live instruction queue, back space |
| iaOffFront | input | 32 | Live instruction queue, front offset |
| iaOffBack | input | 32 | Live instruction queue, back offset |
| faultInsn | input | 32 | Instruction word of the interrupted instruction |
| faultSpace | input | 16 | Space of the associated data address |
| faultOff | input | 32 | Offset of the associated data address |
| entryValid | output | 1 | One-cycle pulse: handler entry |
| entryVector | output | 5 | Vector number taken |
| handlerAddr | output | 32 | Handler fetch address |
| resumeValid | output | 1 | One-cycle pulse: return from interruption |
| pswNext | output | 8 | Status word the core must load on a pulse |
| privNext | output | 2 | Privilege the core must load on a pulse |
| savedPsw | output | 8 | Saved status word |
| iiaSpaceFront | output | 16 | Interruption queue, front space |
| iiaSpaceBack | output | 16 | Interruption queue, back space |
| iiaOffFront | output | 32 | Interruption queue, front offset |
| iiaOffBack | output | 32 | Interruption queue, back offset |
| iirOut | output | 32 | Captured instruction word |
| isrOut | output | 16 | Captured space |
| iorOut | output | 32 | Captured offset |

## Verification
The assertions assume that `rstN` is held low across the first edge, and that request and return strobes are held for exactly one sampled cycle. They also assume the core feeds back the forced status word, which has Q clear, before the queue-freeze behaviour matters. The bench changes inputs only on falling edges and holds each request for one cycle. It drops Q in `pswBefore` whenever it wants the queue copy frozen, and it uses a misaligned `vecBase` throughout, so alignment is exercised on every entry.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

  localparam int REQ_W     = 32;
  localparam int VEC_W     = $clog2(REQ_W);
  localparam int NUM_PRIO  = 23;
  localparam int G4_FIRST  = 20;   // list index where the post-instruction group starts

  // status word bit positions
  localparam int Q_BIT = 0;
  localparam int I_BIT = 1;
  localparam int E_BIT = 2;
  localparam int M_BIT = 3;

  // priority order, highest first; position, not number, decides
  localparam logic [VEC_W-1:0] PRIO_LIST [NUM_PRIO] = '{
    5'd1,
    5'd2, 5'd3, 5'd4, 5'd5, 5'd29,
    5'd6, 5'd7, 5'd15, 5'd16, 5'd17, 5'd26, 5'd27, 5'd28,
    5'd18, 5'd19, 5'd20, 5'd21, 5'd31, 5'd22,
    5'd23, 5'd24, 5'd25
  };

  function automatic logic [REQ_W-1:0] knownMask();
    logic [REQ_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PRIO; i++) m[PRIO_LIST[i]] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic take;      // enter a handler this cycle
    logic resume;    // return from interruption this cycle
    logic useAfter;  // save post-instruction status word
    logic capture;   // load instruction/space/offset registers
    logic track;     // interruption queue follows live queue
    logic machChk;   // high-priority machine check selected
  } ctrlStrobes_t;

endpackage

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REQ_W-1:0]  reqPending,
  input  logic              rfiReq,
  input  logic              qBefore,
  input  logic              qAfter,
  output ctrlStrobes_t      strb,
  output logic [VEC_W-1:0]  selVec
);

  localparam logic [REQ_W-1:0] KNOWN = knownMask();
  localparam int IDX_W = $clog2(NUM_PRIO);

  logic             found;
  logic [IDX_W-1:0] selIdx;
  logic             savedQ;

  // walk from lowest to highest priority so the highest pending wins
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (reqPending[PRIO_LIST[i]]) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign selVec = PRIO_LIST[selIdx];

  always_comb begin
    strb          = '0;
    strb.take     = found;
    strb.useAfter = found && (selIdx >= IDX_W'(G4_FIRST));
    savedQ        = strb.useAfter ? qAfter : qBefore;
    strb.capture  = found && savedQ;
    strb.resume   = rfiReq && !found;
    strb.track    = found ? savedQ : (!rfiReq && qBefore);
    strb.machChk  = found && (selVec == VEC_W'(1));
  end

  p_unknown_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((reqPending & KNOWN) == '0) |-> !strb.take);

  p_rfi_loses_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((reqPending & KNOWN) != '0) |-> !strb.resume);

endmodule

// File: rtl/intr_entry_dpath.sv
module intr_entry_dpath
  import intr_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SPACE_W    = 16,
  parameter int INSN_W     = 32,
  parameter int PSW_W      = 8,
  parameter int PRIV_W     = 2,
  parameter int ALIGN_BITS = 11,
  parameter int SLOT_LOG2  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [VEC_W-1:0]   selVec,
  input  logic [PSW_W-1:0]   pswBefore,
  input  logic [PSW_W-1:0]   pswAfter,
  input  logic [PRIV_W-1:0]  privIn,
  input  logic               defaultEndian,
  input  logic [ADDR_W-1:0]  vecBase,
  input  logic [SPACE_W-1:0] iaSpaceFront,
  input  logic [SPACE_W-1:0] iaSpaceBack,
  input  logic [ADDR_W-1:0]  iaOffFront,
  input  logic [ADDR_W-1:0]  iaOffBack,
  input  logic [INSN_W-1:0]  faultInsn,
  input  logic [SPACE_W-1:0] faultSpace,
  input  logic [ADDR_W-1:0]  faultOff,
  output logic               entryValid,
  output logic [VEC_W-1:0]   entryVector,
  output logic [ADDR_W-1:0]  handlerAddr,
  output logic               resumeValid,
  output logic [PSW_W-1:0]   pswNext,
  output logic [PRIV_W-1:0]  privNext,
  output logic [PSW_W-1:0]   savedPsw,
  output logic [SPACE_W-1:0] iiaSpaceFront,
  output logic [SPACE_W-1:0] iiaSpaceBack,
  output logic [ADDR_W-1:0]  iiaOffFront,
  output logic [ADDR_W-1:0]  iiaOffBack,
  output logic [INSN_W-1:0]  iirOut,
  output logic [SPACE_W-1:0] isrOut,
  output logic [ADDR_W-1:0]  iorOut
);

  localparam logic [PSW_W-1:0] KEEP_MASK = PSW_W'((1 << E_BIT) | (1 << M_BIT));

  logic [PRIV_W-1:0] savedPriv;
  logic [ADDR_W-1:0] alignedBase;
  logic [ADDR_W-1:0] slotOffset;
  logic [PSW_W-1:0]  forcedPsw;

  assign alignedBase = {vecBase[ADDR_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
  assign slotOffset  = ADDR_W'(selVec) << SLOT_LOG2;

  always_comb begin
    forcedPsw        = '0;
    forcedPsw[E_BIT] = defaultEndian;
    forcedPsw[M_BIT] = strb.machChk;
  end

  // pulses and entry results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid  <= 1'b0;
      resumeValid <= 1'b0;
      entryVector <= '0;
      handlerAddr <= '0;
      pswNext     <= '0;
      privNext    <= '0;
      savedPsw    <= '0;
      savedPriv   <= '0;
    end else begin
      entryValid  <= strb.take;
      resumeValid <= strb.resume;
      if (strb.take) begin
        entryVector <= selVec;
        handlerAddr <= alignedBase + slotOffset;
        pswNext     <= forcedPsw;
        privNext    <= '0;
        savedPsw    <= strb.useAfter ? pswAfter : pswBefore;
        savedPriv   <= privIn;
      end else if (strb.resume) begin
        pswNext     <= savedPsw;
        privNext    <= savedPriv;
      end
    end
  end

  // fault detail registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      iirOut <= '0;
      isrOut <= '0;
      iorOut <= '0;
    end else if (strb.capture) begin
      iirOut <= faultInsn;
      isrOut <= faultSpace;
      iorOut <= faultOff;
    end
  end

  // two-entry interruption address queue copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      iiaSpaceFront <= '0;
      iiaSpaceBack  <= '0;
      iiaOffFront   <= '0;
      iiaOffBack    <= '0;
    end else if (strb.track) begin
      iiaSpaceFront <= iaSpaceFront;
      iiaSpaceBack  <= iaSpaceBack;
      iiaOffFront   <= iaOffFront;
      iiaOffBack    <= iaOffBack;
    end
  end

  p_psw_forced_r4: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (((pswNext & ~KEEP_MASK) == '0) &&
                    (pswNext[M_BIT] == (entryVector == VEC_W'(1)))));

  p_priv_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (privNext == '0));

  p_slot_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> ((handlerAddr[SLOT_LOG2-1:0] == '0) &&
                    (handlerAddr[SLOT_LOG2+VEC_W-1:SLOT_LOG2] == entryVector)));

  p_detail_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !strb.capture) |=> $stable({iirOut, isrOut, iorOut}));

  p_queue_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.track |=> $stable({iiaSpaceFront, iiaSpaceBack, iiaOffFront, iiaOffBack}));

  p_resume_psw_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.resume |=> (resumeValid && (pswNext == $past(savedPsw))));

  p_pulse_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(entryValid && resumeValid));

endmodule

// File: rtl/intr_entry_unit.sv
module intr_entry_unit
  import intr_entry_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 16,
  parameter int INSN_W  = 32,
  parameter int PSW_W   = 8,
  parameter int PRIV_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        reqPending,
  input  logic               rfiReq,
  input  logic [PSW_W-1:0]   pswBefore,
  input  logic [PSW_W-1:0]   pswAfter,
  input  logic [PRIV_W-1:0]  privIn,
  input  logic               defaultEndian,
  input  logic [ADDR_W-1:0]  vecBase,
  input  logic [SPACE_W-1:0] iaSpaceFront,
  input  logic [SPACE_W-1:0] iaSpaceBack,
  input  logic [ADDR_W-1:0]  iaOffFront,
  input  logic [ADDR_W-1:0]  iaOffBack,
  input  logic [INSN_W-1:0]  faultInsn,
  input  logic [SPACE_W-1:0] faultSpace,
  input  logic [ADDR_W-1:0]  faultOff,
  output logic               entryValid,
  output logic [4:0]         entryVector,
  output logic [ADDR_W-1:0]  handlerAddr,
  output logic               resumeValid,
  output logic [PSW_W-1:0]   pswNext,
  output logic [PRIV_W-1:0]  privNext,
  output logic [PSW_W-1:0]   savedPsw,
  output logic [SPACE_W-1:0] iiaSpaceFront,
  output logic [SPACE_W-1:0] iiaSpaceBack,
  output logic [ADDR_W-1:0]  iiaOffFront,
  output logic [ADDR_W-1:0]  iiaOffBack,
  output logic [INSN_W-1:0]  iirOut,
  output logic [SPACE_W-1:0] isrOut,
  output logic [ADDR_W-1:0]  iorOut
);

  ctrlStrobes_t     strb;
  logic [VEC_W-1:0] selVec;

  intr_entry_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqPending (reqPending),
    .rfiReq     (rfiReq),
    .qBefore    (pswBefore[Q_BIT]),
    .qAfter     (pswAfter[Q_BIT]),
    .strb       (strb),
    .selVec     (selVec)
  );

  intr_entry_dpath #(
    .ADDR_W  (ADDR_W),
    .SPACE_W (SPACE_W),
    .INSN_W  (INSN_W),
    .PSW_W   (PSW_W),
    .PRIV_W  (PRIV_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .selVec        (selVec),
    .pswBefore     (pswBefore),
    .pswAfter      (pswAfter),
    .privIn        (privIn),
    .defaultEndian (defaultEndian),
    .vecBase       (vecBase),
    .iaSpaceFront  (iaSpaceFront),
    .iaSpaceBack   (iaSpaceBack),
    .iaOffFront    (iaOffFront),
    .iaOffBack     (iaOffBack),
    .faultInsn     (faultInsn),
    .faultSpace    (faultSpace),
    .faultOff      (faultOff),
    .entryValid    (entryValid),
    .entryVector   (entryVector),
    .handlerAddr   (handlerAddr),
    .resumeValid   (resumeValid),
    .pswNext       (pswNext),
    .privNext      (privNext),
    .savedPsw      (savedPsw),
    .iiaSpaceFront (iiaSpaceFront),
    .iiaSpaceBack  (iiaSpaceBack),
    .iiaOffFront   (iiaOffFront),
    .iiaOffBack    (iiaOffBack),
    .iirOut        (iirOut),
    .isrOut        (isrOut),
    .iorOut        (iorOut)
  );

endmodule

// File: tb/tb_intr_entry_unit.sv
module tb_intr_entry_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 13;
  // {request bits, expected vector}
  localparam logic [36:0] ROWS [NROWS] = '{
    {32'h0000_0002, 5'd1},
    {32'hFFFF_FFFF, 5'd1},
    {32'h2000_0004, 5'd2},
    {32'h2000_0040, 5'd29},
    {32'h0000_0030, 5'd4},
    {32'h0404_0000, 5'd26},
    {32'h8040_0000, 5'd31},
    {32'h1000_8000, 5'd15},
    {32'h00C0_0000, 5'd22},
    {32'h0300_0000, 5'd24},
    {32'h0200_0000, 5'd25},
    {32'h000C_0000, 5'd18},
    {32'h0200_0101, 5'd25}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqPending = '0;
  logic        rfiReq = 1'b0;
  logic [7:0]  pswBefore = '0;
  logic [7:0]  pswAfter = '0;
  logic [1:0]  privIn = '0;
  logic        defaultEndian = 1'b0;
  logic [31:0] vecBase = '0;
  logic [15:0] iaSpaceFront = '0, iaSpaceBack = '0;
  logic [31:0] iaOffFront = '0, iaOffBack = '0;
  logic [31:0] faultInsn = '0;
  logic [15:0] faultSpace = '0;
  logic [31:0] faultOff = '0;

  logic        entryValid, resumeValid;
  logic [4:0]  entryVector;
  logic [31:0] handlerAddr;
  logic [7:0]  pswNext, savedPsw;
  logic [1:0]  privNext;
  logic [15:0] iiaSpaceFront, iiaSpaceBack, isrOut;
  logic [31:0] iiaOffFront, iiaOffBack, iirOut, iorOut;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_unit dut (
    .clk(clk), .rstN(rstN), .reqPending(reqPending), .rfiReq(rfiReq),
    .pswBefore(pswBefore), .pswAfter(pswAfter), .privIn(privIn),
    .defaultEndian(defaultEndian), .vecBase(vecBase),
    .iaSpaceFront(iaSpaceFront), .iaSpaceBack(iaSpaceBack),
    .iaOffFront(iaOffFront), .iaOffBack(iaOffBack),
    .faultInsn(faultInsn), .faultSpace(faultSpace), .faultOff(faultOff),
    .entryValid(entryValid), .entryVector(entryVector), .handlerAddr(handlerAddr),
    .resumeValid(resumeValid), .pswNext(pswNext), .privNext(privNext),
    .savedPsw(savedPsw), .iiaSpaceFront(iiaSpaceFront), .iiaSpaceBack(iiaSpaceBack),
    .iiaOffFront(iiaOffFront), .iiaOffBack(iiaOffBack),
    .iirOut(iirOut), .isrOut(isrOut), .iorOut(iorOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // one sampled cycle: inputs were set after a falling edge, results read at the next one
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] expBase;
    logic [7:0]  expPsw;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk("R11 entryValid", 64'(entryValid), 64'd0);
    chk("R11 pswNext", 64'(pswNext), 64'd0);
    chk("R11 handlerAddr", 64'(handlerAddr), 64'd0);
    chk("R11 iirOut", 64'(iirOut), 64'd0);
    chk("R11 iiaOffFront", 64'(iiaOffFront), 64'd0);
    rstN = 1'b1;

    // table walk: R1 priority, R3 address, R4 status, R5 privilege, R6 saved word
    pswBefore = 8'hB1;
    pswAfter = 8'h4D;
    privIn = 2'd3;
    defaultEndian = 1'b1;
    vecBase = 32'h1234_5FFF;
    expBase = 32'h1234_5800;
    for (int r = 0; r < NROWS; r++) begin
      logic [4:0] ev;
      ev = ROWS[r][4:0];
      reqPending = ROWS[r][36:5];
      step();
      reqPending = '0;
      chk("R1 entryValid", 64'(entryValid), 64'd1);
      chk("R1 vector", 64'(entryVector), 64'(ev));
      chk("R3 handlerAddr", 64'(handlerAddr), 64'(expBase + 32'd32 * 32'(ev)));
      expPsw = 8'h04 | ((ev == 5'd1) ? 8'h08 : 8'h00);
      chk("R4 pswNext", 64'(pswNext), 64'(expPsw));
      chk("R5 privNext", 64'(privNext), 64'd0);
      chk("R6 savedPsw", 64'(savedPsw),
          64'((ev >= 5'd23 && ev <= 5'd25) ? 8'h4D : 8'hB1));
      step();
      chk("R1 pulse ends", 64'(entryValid), 64'd0);
    end

    // R2: only unrecognised bits pending
    reqPending = 32'h4000_7F01;
    step();
    reqPending = '0;
    chk("R2 no entry", 64'(entryValid), 64'd0);
    chk("R2 pswNext unchanged", 64'(pswNext), 64'h04);

    // R8: tracking with Q=1, then freeze with Q=0
    iaSpaceFront = 16'h0011; iaSpaceBack = 16'h0022;
    iaOffFront = 32'h0000_1000; iaOffBack = 32'h0000_1004;
    step();
    chk("R8 track front", 64'(iiaOffFront), 64'h1000);
    chk("R8 track back space", 64'(iiaSpaceBack), 64'h22);
    pswBefore = 8'hB0;
    iaSpaceFront = 16'h0099; iaOffFront = 32'h0000_2000; iaOffBack = 32'h0000_2004;
    step();
    chk("R8 frozen front", 64'(iiaOffFront), 64'h1000);
    chk("R8 frozen back", 64'(iiaOffBack), 64'h1004);
    chk("R8 frozen space", 64'(iiaSpaceFront), 64'h11);

    // R7: capture with Q=1 on a group 3 vector
    pswBefore = 8'hB1;
    faultInsn = 32'hCAFE_0001; faultSpace = 16'h0ABC; faultOff = 32'h0000_0F00;
    reqPending = 32'h0000_0040;
    step();
    reqPending = '0;
    chk("R7 iir loaded", 64'(iirOut), 64'hCAFE_0001);
    chk("R7 isr loaded", 64'(isrOut), 64'h0ABC);
    chk("R7 ior loaded", 64'(iorOut), 64'h0F00);
    chk("R8 entry with Q=1 tracks", 64'(iiaOffFront), 64'h2000);

    // R7: no capture when saved Q=0
    pswBefore = 8'hB0;
    faultInsn = 32'hDEAD_0002; faultOff = 32'h0000_0E00;
    iaOffFront = 32'h0000_3000;
    reqPending = 32'h0000_0080;
    step();
    reqPending = '0;
    chk("R7 iir held", 64'(iirOut), 64'hCAFE_0001);
    chk("R7 ior held", 64'(iorOut), 64'h0F00);
    chk("R8 entry with Q=0 frozen", 64'(iiaOffFront), 64'h2000);

    // R7/R6: group 4 uses the post-instruction Q
    pswAfter = 8'h4D;
    privIn = 2'd2;
    faultInsn = 32'hBEEF_0003;
    reqPending = 32'h0080_0000;
    step();
    reqPending = '0;
    chk("R7 group4 capture", 64'(iirOut), 64'hBEEF_0003);
    chk("R6 group4 saved", 64'(savedPsw), 64'h4D);
    chk("R8 group4 tracks", 64'(iiaOffFront), 64'h3000);

    // R9: return restores the saved word and privilege, queue held
    iaOffFront = 32'h0000_4000;
    rfiReq = 1'b1;
    step();
    rfiReq = 1'b0;
    chk("R9 resumeValid", 64'(resumeValid), 64'd1);
    chk("R9 no entry", 64'(entryValid), 64'd0);
    chk("R9 pswNext", 64'(pswNext), 64'h4D);
    chk("R9 privNext", 64'(privNext), 64'd2);
    chk("R9 queue held", 64'(iiaOffFront), 64'h3000);
    step();
    chk("R9 pulse ends", 64'(resumeValid), 64'd0);

    // R10: request and return together
    reqPending = 32'h0000_0010;
    rfiReq = 1'b1;
    step();
    reqPending = '0;
    rfiReq = 1'b0;
    chk("R10 entry taken", 64'(entryValid), 64'd1);
    chk("R10 return ignored", 64'(resumeValid), 64'd0);
    chk("R10 vector", 64'(entryVector), 64'd4);
    chk("R10 pswNext forced", 64'(pswNext), 64'h04);

    step();
    finishRun();
  end

endmodule